// File: doc/BRIEF.md
# Quadrature Step Accumulator with Report Timer

This block sits behind a quadrature pin decoder. On every sample strobe it receives one decoded motion code: a single step forward, a single step backward, no motion, or a marker saying that both phases changed at once, so the direction cannot be known. Single steps are summed into a signed accumulator whose range is set by a parameter. The double-transition marker is counted but never summed. A step that would push the sum past either end of its range is dropped, and an overflow pulse is raised instead of letting the sum wrap.

A sample counter splits the stream into report periods. A 4-bit code selects the length of a period from a fixed, nonlinear set of lengths. When a period closes, the block pulses a report-ready output if any step was seen in it, and a double-ready output if any double-transition marker was seen in it. A read-and-clear request copies the sum into a snapshot register and restarts the sum from zero in the same cycle. Both values come out sign-extended to a full word.

Top module: `qacc_top`

## Requirements
- R1: `sampleCode` is a 2-bit two's-complement step: 2'b01 adds +1, 2'b11 adds -1, 2'b00 adds nothing. The sum is applied only when `sampleValid` is high, and `accOut` shows the new value one cycle after the strobe.
- R2: The code 2'b10 (double transition) never changes the accumulator.
- R3: The accumulator stays within -2^(ACC_W-1) to 2^(ACC_W-1)-1. A step that would leave this range is dropped, and `accOverflow` is high for exactly the one cycle after that strobe.
- R4: A `readClear` pulse loads `snapOut` with the accumulator value held before the edge and sets the accumulator to zero. Both changes appear one cycle later.
- R5: When `readClear` and a valid step arrive in the same cycle, the snapshot takes the value from before the step, and the accumulator becomes zero plus that step.
- R6: The period length in valid samples comes from `periodCode`: code 0 gives 10, codes 1 to 7 give 40 times the code (40 to 280), code 8 gives 1, and codes 9 to 15 act as code 8.
- R7: `reportRdy` is high for one cycle, the cycle after the strobe that closes a period. It rises only if that period contained at least one 2'b01 or 2'b11 sample. A step that was dropped for overflow still counts.
- R8: `dblRdy` is high for one cycle, the cycle after the strobe that closes a period. It rises only if that period contained at least one 2'b10 sample.
- R9: Only strobes with `sampleValid` high count toward the period. The count restarts after each closing strobe. If the count already reaches a newly selected, shorter length, the next valid strobe closes the period.
- R10: Reset clears the accumulator, the snapshot, the count and all pulses. `accOut` and `snapOut` are the register values sign-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Sample strobe |
| sampleCode | input | 2 | Decoded step code |
| periodCode | input | 4 | Report period selector |
| readClear | input | 1 | Copy accumulator to snapshot and clear it |
| accOut | output | 32 | Sign-extended accumulator |
| snapOut | output | 32 | Sign-extended snapshot |
| reportRdy | output | 1 | Period closed, with step motion |
| dblRdy | output | 1 | Period closed, with a double transition |
| accOverflow | output | 1 | A step was dropped at the range limit |

## Verification
The bench builds the block with `ACC_W = 5`, so the sum saturates at -16 and +15. A few dozen steps therefore reach both limits, the overflow drop, and a read-and-clear taken at a limit. The period parameters keep their defaults, and the bench sweeps all sixteen period codes. For each code it drives several period lengths with four traffic shapes: idle, mixed steps, doubles only, and steps with gaps in the strobe. This covers both report pulses being suppressed or raised, the counter carrying over across a code change, and clears that land together with a step.

// File: rtl/qacc_pkg.sv
package qacc_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic up;
    logic down;
    logic clear;
  } qaccCtrl_t;

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_FWD  = 2'b01;
  localparam logic [1:0] CODE_DBL  = 2'b10;
  localparam logic [1:0] CODE_BWD  = 2'b11;
endpackage

// File: rtl/qacc_ctrl.sv
module qacc_ctrl
  import qacc_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int BASE_LEN = 10,
  parameter int STEP_LEN = 40,
  parameter int SCALED_CODES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [1:0]        sampleCode,
  input  logic [CODE_W-1:0] periodCode,
  input  logic              readClear,
  output qaccCtrl_t         ctrl,
  output logic              reportRdy,
  output logic              dblRdy
);
  localparam int MAX_LEN = (STEP_LEN * (SCALED_CODES - 1) > BASE_LEN)
                           ? STEP_LEN * (SCALED_CODES - 1) : BASE_LEN;
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodLen;
  logic [CNT_W:0]   cntInc;
  logic             sawStep, sawDbl;
  logic             isStep, isDbl, closing;

  function automatic logic [CNT_W-1:0] lenOf(input logic [CODE_W-1:0] c);
    if (c == '0) return CNT_W'(BASE_LEN);
    else if (int'(c) < SCALED_CODES) return CNT_W'(STEP_LEN * int'(c));
    else return CNT_W'(1);
  endfunction

  assign periodLen = lenOf(periodCode);
  assign isStep  = sampleValid && (sampleCode == CODE_FWD || sampleCode == CODE_BWD);
  assign isDbl   = sampleValid && (sampleCode == CODE_DBL);
  assign cntInc  = {1'b0, cnt} + 1'b1;
  assign closing = sampleValid && (cntInc >= {1'b0, periodLen});

  assign ctrl.up    = sampleValid && (sampleCode == CODE_FWD);
  assign ctrl.down  = sampleValid && (sampleCode == CODE_BWD);
  assign ctrl.clear = readClear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      sawStep   <= 1'b0;
      sawDbl    <= 1'b0;
      reportRdy <= 1'b0;
      dblRdy    <= 1'b0;
    end else if (closing) begin
      cnt       <= '0;
      sawStep   <= 1'b0;
      sawDbl    <= 1'b0;
      reportRdy <= sawStep || isStep;
      dblRdy    <= sawDbl || isDbl;
    end else begin
      reportRdy <= 1'b0;
      dblRdy    <= 1'b0;
      if (sampleValid) begin
        cnt     <= cntInc[CNT_W-1:0];
        sawStep <= sawStep || isStep;
        sawDbl  <= sawDbl || isDbl;
      end
    end
  end

  // R7: a report pulse only follows a sample strobe
  a_r7_report_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    reportRdy |-> $past(sampleValid));
  // R8: a double pulse only follows a sample strobe
  a_r8_dbl_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    dblRdy |-> $past(sampleValid));
  // R9: the count never reaches the longest period
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) < MAX_LEN);
  // R9: idle cycles leave the count alone
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(cnt));
endmodule

// File: rtl/qacc_datapath.sv
module qacc_datapath
  import qacc_pkg::*;
#(
  parameter int ACC_W = 11,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  qaccCtrl_t        ctrl,
  output logic [OUT_W-1:0] accOut,
  output logic [OUT_W-1:0] snapOut,
  output logic             accOverflow
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam int EXT_W = OUT_W - ACC_W;

  logic [ACC_W-1:0] acc, snap, base, accNext;
  logic             dropUp, dropDown;

  always_comb begin
    base     = ctrl.clear ? '0 : acc;
    dropUp   = ctrl.up && (base == ACC_MAX);
    dropDown = ctrl.down && (base == ACC_MIN);
    accNext  = base;
    if (ctrl.up && !dropUp) accNext = base + 1'b1;
    else if (ctrl.down && !dropDown) accNext = base - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc         <= '0;
      snap        <= '0;
      accOverflow <= 1'b0;
    end else begin
      acc         <= accNext;
      accOverflow <= dropUp || dropDown;
      if (ctrl.clear) snap <= acc;
    end
  end

  assign accOut  = {{EXT_W{acc[ACC_W-1]}}, acc};
  assign snapOut = {{EXT_W{snap[ACC_W-1]}}, snap};

  // R3: a dropped step leaves the sum where it was
  a_r3_drop_keeps_value: assert property (@(posedge clk) disable iff (!rstN)
    accOverflow |-> acc == $past(acc));
  // R3: drops happen only at a range limit
  a_r3_drop_at_limit: assert property (@(posedge clk) disable iff (!rstN)
    accOverflow |-> ($past(acc) == ACC_MAX || $past(acc) == ACC_MIN));
  // R4: the snapshot takes the pre-clear value
  a_r4_snapshot: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> snap == $past(acc));
endmodule

// File: rtl/qacc_top.sv
module qacc_top #(
  parameter int ACC_W = 11,
  parameter int BASE_LEN = 10,
  parameter int STEP_LEN = 40,
  parameter int SCALED_CODES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic [1:0]  sampleCode,
  input  logic [3:0]  periodCode,
  input  logic        readClear,
  output logic [31:0] accOut,
  output logic [31:0] snapOut,
  output logic        reportRdy,
  output logic        dblRdy,
  output logic        accOverflow
);
  import qacc_pkg::*;

  qaccCtrl_t ctrl;

  qacc_ctrl #(
    .CODE_W(4), .BASE_LEN(BASE_LEN), .STEP_LEN(STEP_LEN), .SCALED_CODES(SCALED_CODES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleCode(sampleCode),
    .periodCode(periodCode), .readClear(readClear), .ctrl(ctrl),
    .reportRdy(reportRdy), .dblRdy(dblRdy)
  );

  qacc_datapath #(.ACC_W(ACC_W), .OUT_W(32)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .accOut(accOut), .snapOut(snapOut), .accOverflow(accOverflow)
  );

  // R2: a double-transition marker does not move the sum
  a_r2_double_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleCode == CODE_DBL && !readClear) |=> accOut == $past(accOut));
endmodule

// File: tb/tb_qacc_top.sv
module tb_qacc_top;
  localparam int ACC_W = 5;
  localparam int ACC_HI = 15;
  localparam int ACC_LO = -16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [1:0] sampleCode = 2'b00;
  logic [3:0] periodCode = 4'd0;
  logic readClear = 1'b0;
  logic [31:0] accOut, snapOut;
  logic reportRdy, dblRdy, accOverflow;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference state
  int mAcc = 0, mSnap = 0, mCnt = 0;
  bit mStep = 0, mDbl = 0;
  bit eRep = 0, eDbl = 0, eOvf = 0;

  always #10 clk = ~clk;

  qacc_top #(.ACC_W(ACC_W)) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleCode(sampleCode),
    .periodCode(periodCode), .readClear(readClear), .accOut(accOut),
    .snapOut(snapOut), .reportRdy(reportRdy), .dblRdy(dblRdy), .accOverflow(accOverflow)
  );

  // R6: period lengths
  function automatic int lenOf(input int c);
    if (c == 0) return 10;
    if (c <= 7) return 40 * c;
    return 1;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R1 accOut", longint'($signed(accOut)), mAcc);
    chk("R4 snapOut", longint'($signed(snapOut)), mSnap);
    chk("R3 accOverflow", accOverflow, eOvf);
    chk("R7 reportRdy", reportRdy, eRep);
    chk("R8 dblRdy", dblRdy, eDbl);
  endtask

  // Drive one cycle at the falling edge, update the model, check at the next falling edge
  task automatic cyc(input bit v, input logic [1:0] c, input bit clr);
    int base, d, n, len;
    bit isStep, isDbl;
    sampleValid = v; sampleCode = c; readClear = clr;
    eOvf = 0; eRep = 0; eDbl = 0;
    if (clr) mSnap = mAcc;                 // R4, R5
    base = clr ? 0 : mAcc;
    d = !v ? 0 : (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;   // R1, R2
    n = base + d;
    if (n > ACC_HI || n < ACC_LO) begin eOvf = 1; mAcc = base; end  // R3
    else mAcc = n;
    isStep = v && (c == 2'b01 || c == 2'b11);
    isDbl = v && (c == 2'b10);
    len = lenOf(int'(periodCode));
    if (v) begin                          // R9
      if (mCnt + 1 >= len) begin
        eRep = mStep | isStep; eDbl = mDbl | isDbl;
        mCnt = 0; mStep = 0; mDbl = 0;
      end else begin
        mCnt++; mStep |= isStep; mDbl |= isDbl;
      end
    end
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll();                           // R10 reset values
    rstN = 1'b1;
    @(negedge clk);
    checkAll();

    // Period sweep over all sixteen codes and four traffic shapes
    for (int pc = 0; pc < 16; pc++) begin
      periodCode = 4'(pc);
      for (int shape = 0; shape < 4; shape++) begin
        int n = lenOf(pc) * 2 + 3;
        for (int i = 0; i < n; i++) begin
          logic [1:0] c;
          bit v, clr;
          v = 1; clr = 0;
          case (shape)
            0: c = 2'b00;
            1: c = 2'((i * 3 + pc) % 4);
            2: c = (i % 3 == 0) ? 2'b10 : 2'b00;
            default: begin c = (i % 2) ? 2'b01 : 2'b11; v = (i % 3 != 2); end
          endcase
          clr = (i % 17 == 5);            // R5 clears collide with strobes
          cyc(v, c, clr);
        end
      end
    end

    // R3 saturation at both limits, R5 clear at a limit
    periodCode = 4'd8;
    cyc(0, 2'b00, 1);
    for (int i = 0; i < 20; i++) cyc(1, 2'b01, 0);
    cyc(1, 2'b10, 0);                     // R2 at the top limit
    for (int i = 0; i < 40; i++) cyc(1, 2'b11, 0);
    cyc(1, 2'b01, 1);                     // R5 snapshot -16, acc becomes +1
    cyc(0, 2'b00, 0);
    for (int i = 0; i < 20; i++) cyc(1, 2'b11, 0);
    cyc(1, 2'b11, 1);                     // R5 snapshot -16, acc becomes -1
    // R9 shorter code while a count is pending
    periodCode = 4'd2;
    for (int i = 0; i < 50; i++) cyc(1, 2'b00, 0);
    periodCode = 4'd0;
    cyc(1, 2'b01, 0);
    cyc(0, 2'b01, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule